// File: doc/BRIEF.md
# Per-Bank Row Buffer Command Sequencer

This block sits between a request source and a DRAM command slot. For every bank it records whether a row is held open in the row buffer and, if so, which row. Each incoming column access (bank, row, column, read or write) is turned into the shortest legal series of DRAM commands that reaches that column. An empty bank needs an activate first. A bank open on the wanted row needs only the column command. A bank open on another row needs a precharge and then an activate. The sequencer emits exactly one command in each slot where the command slot signals ready. It acknowledges the request in the cycle its column command appears.

A run-time policy input selects between keeping the row open after an access and closing it at once. With the close policy, a precharge to the same bank follows each column command in the next ready slot, ahead of any waiting request. A free-running count of issued commands lets the two policies be compared on the same traffic. Timing gaps between commands are not modelled: every command takes one slot.

Top module: `rowbuf_cmd_seq`

## Requirements
- R1: While reset is held and until the first command, cmd_valid and req_ack are 0 and cmd_count is 0. After reset every bank's row buffer is empty, so the first access to any bank begins with an activate.
- R2: A request to a bank with no open row produces an activate (op 1) carrying the request's row, followed by the column command for the same bank, row and column.
- R3: A request whose row equals the row open in its bank produces only the column command.
- R4: A request whose row differs from the open row produces a precharge (op 0), then an activate, then the column command, all to the request's bank.
- R5: With close_pol low, the row stays open after the column command, so a following request to that row needs only its column command.
- R6: With close_pol high when a column command issues, the next ready slot carries a precharge to that bank. The following request to that bank then starts with an activate.
- R7: A command appears on the outputs, with cmd_valid high for one cycle, in the cycle after each clock edge at which slot_rdy is high and work is pending. No command appears after an edge at which slot_rdy is low.
- R8: req_ack is high for exactly the cycle in which the request's column command is on the outputs, and in no other cycle.
- R9: cmd_count increases by one for every cycle in which cmd_valid is high and is otherwise unchanged.
- R10: A pending close-policy precharge is issued before a request that is already waiting, even when both are ready in the same slot.
- R11: Command codes are 0 precharge, 1 activate, 2 read, 3 write. Precharge carries row 0 and column 0, activate carries column 0, and column commands carry the request's row and column.
- R12: Row-buffer state is kept per bank: opening or changing a row in one bank does not change the open row of another bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| close_pol | input | 1 | 1 selects close-page, 0 selects open-page |
| req_valid | input | 1 | Request present; held until req_ack |
| req_bank | input | BK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_ack | output | 1 | Request completed by its column command this cycle |
| slot_rdy | input | 1 | The command slot can accept a command at the next edge |
| cmd_valid | output | 1 | A command is on the command outputs |
| cmd_op | output | 2 | Command code (see R11) |
| cmd_bank | output | BK_W | Command bank |
| cmd_row | output | ROW_W | Command row |
| cmd_col | output | COL_W | Command column |
| cmd_count | output | CNT_W | Number of commands issued since reset |

## Verification
The two functions that can land in the same slot are the close-policy precharge owed for the last access and the first command of a request already waiting. The bench provokes this by presenting the next request in the very cycle the previous acknowledge is seen, with slot_rdy held high. The scoreboard then expects the precharge first and the new request's commands after it. A second clash is a waiting request against a withheld slot: slot_rdy is held low and then toggled. Any command that appears after a low slot, or any missing command after a high slot with work queued, is reported.

// File: rtl/rbseq_pkg.sv
package rbseq_pkg;
  typedef enum logic [1:0] {
    OP_PRE = 2'd0,
    OP_ACT = 2'd1,
    OP_RD  = 2'd2,
    OP_WR  = 2'd3
  } op_e;
endpackage

// File: rtl/rbseq_rst_sync.sv
module rbseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rbseq_bank_table.sv
module rbseq_bank_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int BK_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic             upd_open,
  input  logic [BK_W-1:0]  upd_bank,
  input  logic [ROW_W-1:0] upd_row,
  input  logic [BK_W-1:0]  rd_bank,
  output logic             rd_open,
  output logic [ROW_W-1:0] rd_row
);
  logic [NUM_BANKS-1:0] open_q;
  logic [ROW_W-1:0]     row_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = upd_en && (upd_bank == BK_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   open_q[b] <= 1'b0;
      else if (sel) open_q[b] <= upd_open;
    end

    always_ff @(posedge clk) begin
      if (sel && upd_open) row_q[b] <= upd_row;
    end
  end

  assign rd_open = open_q[rd_bank];
  assign rd_row  = row_q[rd_bank];
endmodule

// File: rtl/rbseq_decider.sv
module rbseq_decider
  import rbseq_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 8,
  parameter int BK_W  = 2
) (
  input  logic             slot_rdy,
  input  logic             pend_pre,
  input  logic [BK_W-1:0]  pend_bank,
  input  logic             req_valid,
  input  logic [BK_W-1:0]  req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_write,
  input  logic             bk_open,
  input  logic [ROW_W-1:0] bk_row,
  output logic             issue,
  output logic [1:0]       op,
  output logic [BK_W-1:0]  bank,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic             col_issue,
  output logic             pend_done,
  output logic             tbl_en,
  output logic             tbl_open
);
  always_comb begin
    issue     = 1'b0;
    op        = OP_PRE;
    bank      = req_bank;
    row       = '0;
    col       = '0;
    col_issue = 1'b0;
    pend_done = 1'b0;
    tbl_en    = 1'b0;
    tbl_open  = 1'b0;
    if (slot_rdy) begin
      if (pend_pre) begin
        issue     = 1'b1;
        op        = OP_PRE;
        bank      = pend_bank;
        pend_done = 1'b1;
        tbl_en    = 1'b1;
      end else if (req_valid) begin
        issue = 1'b1;
        if (!bk_open) begin
          op       = OP_ACT;
          row      = req_row;
          tbl_en   = 1'b1;
          tbl_open = 1'b1;
        end else if (bk_row != req_row) begin
          op     = OP_PRE;
          tbl_en = 1'b1;
        end else begin
          op        = req_write ? OP_WR : OP_RD;
          row       = req_row;
          col       = req_col;
          col_issue = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rbseq_out_reg.sv
module rbseq_out_reg #(
  parameter int ROW_W = 12,
  parameter int COL_W = 8,
  parameter int BK_W  = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             col_issue,
  input  logic [1:0]       op,
  input  logic [BK_W-1:0]  bank,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  output logic             cmd_valid,
  output logic             req_ack,
  output logic [1:0]       cmd_op,
  output logic [BK_W-1:0]  cmd_bank,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic [CNT_W-1:0] cmd_count
);
  logic [CNT_W-1:0] count_d;

  always_comb begin
    count_d = cmd_count + CNT_W'(issue);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      req_ack   <= 1'b0;
      cmd_count <= '0;
    end else begin
      cmd_valid <= issue;
      req_ack   <= col_issue;
      cmd_count <= count_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_op   <= '0;
      cmd_bank <= '0;
      cmd_row  <= '0;
      cmd_col  <= '0;
    end else if (issue) begin
      cmd_op   <= op;
      cmd_bank <= bank;
      cmd_row  <= row;
      cmd_col  <= col;
    end
  end
endmodule

// File: rtl/rowbuf_cmd_seq.sv
module rowbuf_cmd_seq #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  parameter int CNT_W     = 16,
  localparam int BK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             close_pol,
  input  logic             req_valid,
  input  logic [BK_W-1:0]  req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_write,
  output logic             req_ack,
  input  logic             slot_rdy,
  output logic             cmd_valid,
  output logic [1:0]       cmd_op,
  output logic [BK_W-1:0]  cmd_bank,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic [CNT_W-1:0] cmd_count
);
  logic             rst_int_n;
  logic             bk_open;
  logic [ROW_W-1:0] bk_row;
  logic             issue, col_issue, pend_done, tbl_en, tbl_open;
  logic [1:0]       dec_op;
  logic [BK_W-1:0]  dec_bank;
  logic [ROW_W-1:0] dec_row;
  logic [COL_W-1:0] dec_col;
  logic             pend_q, pend_d;
  logic [BK_W-1:0]  pend_bank_q, pend_bank_d;

  rbseq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  rbseq_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .BK_W(BK_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .upd_en   (tbl_en),
    .upd_open (tbl_open),
    .upd_bank (dec_bank),
    .upd_row  (dec_row),
    .rd_bank  (req_bank),
    .rd_open  (bk_open),
    .rd_row   (bk_row)
  );

  rbseq_decider #(.ROW_W(ROW_W), .COL_W(COL_W), .BK_W(BK_W)) u_dec (
    .slot_rdy  (slot_rdy),
    .pend_pre  (pend_q),
    .pend_bank (pend_bank_q),
    .req_valid (req_valid),
    .req_bank  (req_bank),
    .req_row   (req_row),
    .req_col   (req_col),
    .req_write (req_write),
    .bk_open   (bk_open),
    .bk_row    (bk_row),
    .issue     (issue),
    .op        (dec_op),
    .bank      (dec_bank),
    .row       (dec_row),
    .col       (dec_col),
    .col_issue (col_issue),
    .pend_done (pend_done),
    .tbl_en    (tbl_en),
    .tbl_open  (tbl_open)
  );

  always_comb begin
    pend_d      = pend_q;
    pend_bank_d = pend_bank_q;
    if (pend_done) begin
      pend_d = 1'b0;
    end else if (col_issue) begin
      pend_d      = close_pol;
      pend_bank_d = req_bank;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pend_q      <= 1'b0;
      pend_bank_q <= '0;
    end else begin
      pend_q      <= pend_d;
      pend_bank_q <= pend_bank_d;
    end
  end

  rbseq_out_reg #(.ROW_W(ROW_W), .COL_W(COL_W), .BK_W(BK_W), .CNT_W(CNT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .issue     (issue),
    .col_issue (col_issue),
    .op        (dec_op),
    .bank      (dec_bank),
    .row       (dec_row),
    .col       (dec_col),
    .cmd_valid (cmd_valid),
    .req_ack   (req_ack),
    .cmd_op    (cmd_op),
    .cmd_bank  (cmd_bank),
    .cmd_row   (cmd_row),
    .cmd_col   (cmd_col),
    .cmd_count (cmd_count)
  );
endmodule

// File: rtl/rbseq_chk.sv
module rbseq_chk #(
  parameter int BK_W  = 2,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             close_pol,
  input logic             slot_rdy,
  input logic             req_ack,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic [BK_W-1:0]  cmd_bank,
  input logic [CNT_W-1:0] cmd_count,
  input logic             pend_q,
  input logic [BK_W-1:0]  pend_bank_q
);
  // R8
  ack_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (cmd_valid && cmd_op[1]));

  // R7
  no_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(slot_rdy) |-> !cmd_valid);

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_count == $past(cmd_count) + CNT_W'(cmd_valid));

  // R6
  close_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op[1] && $past(close_pol)) |-> pend_q);

  // R10
  close_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && slot_rdy) |=> (cmd_valid && cmd_op == 2'd0 && cmd_bank == $past(pend_bank_q)));
endmodule

bind rowbuf_cmd_seq rbseq_chk #(.BK_W(BK_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .close_pol   (close_pol),
  .slot_rdy    (slot_rdy),
  .req_ack     (req_ack),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .cmd_bank    (cmd_bank),
  .cmd_count   (cmd_count),
  .pend_q      (pend_q),
  .pend_bank_q (pend_bank_q)
);

// File: tb/rowbuf_cmd_seq_tb.sv
`timescale 1ns/1ps
module rowbuf_cmd_seq_tb;
  localparam int NB = 4, ROW_W = 12, COL_W = 8, CNT_W = 16, BK_W = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n, close_pol, req_valid, req_write, req_ack, slot_rdy, cmd_valid;
  logic [BK_W-1:0]  req_bank, cmd_bank;
  logic [ROW_W-1:0] req_row, cmd_row;
  logic [COL_W-1:0] req_col, cmd_col;
  logic [1:0]       cmd_op;
  logic [CNT_W-1:0] cmd_count;

  rowbuf_cmd_seq #(.NUM_BANKS(NB), .ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .close_pol(close_pol), .req_valid(req_valid),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_write(req_write),
    .req_ack(req_ack), .slot_rdy(slot_rdy), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_count(cmd_count)
  );

  typedef struct {
    logic [1:0]       op;
    logic [BK_W-1:0]  bank;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    string            tag;
  } exp_t;

  exp_t             sb_q[$];
  bit               m_open [NB];
  logic [ROW_W-1:0] m_row  [NB];
  bit               m_close;
  int               checks = 0, fails = 0, mon_cnt = 0;
  bit               mon_en = 0;
  int               slot_mode = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(logic [1:0] op, int b, logic [ROW_W-1:0] r, logic [COL_W-1:0] c, string tag);
    exp_t e;
    e.op = op; e.bank = BK_W'(b); e.row = r; e.col = c; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Driver: pushes the expected commands, then holds the request until acknowledged
  task automatic send(int b, logic [ROW_W-1:0] r, logic [COL_W-1:0] c, bit wr, string hit_tag);
    string ctag;
    int    guard;
    ctag = hit_tag;
    if (m_open[b] && m_row[b] != r) begin
      push(2'd0, b, '0, '0, "R4");
      m_open[b] = 0;
      ctag = "R4";
    end
    if (!m_open[b]) begin
      push(2'd1, b, r, '0, "R2");
      m_open[b] = 1;
      m_row[b]  = r;
      if (ctag == hit_tag) ctag = "R2";
    end
    push(wr ? 2'd3 : 2'd2, b, r, c, ctag);
    if (m_close) begin
      push(2'd0, b, '0, '0, "R6 R10");
      m_open[b] = 0;
    end
    req_bank  = BK_W'(b);
    req_row   = r;
    req_col   = c;
    req_write = wr;
    req_valid = 1'b1;
    guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (req_ack || guard > 200) break;
    end
    req_valid = 1'b0;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while (sb_q.size() != 0 && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R7", "queue left undrained", sb_q.size(), 0);
  endtask

  // Slot-ready pattern generator
  always @(negedge clk) begin
    case (slot_mode)
      0:       slot_rdy <= 1'b1;
      1:       slot_rdy <= ~slot_rdy;
      default: slot_rdy <= 1'b0;
    endcase
  end

  // Monitor: pops and compares every command
  always @(posedge clk) begin
    #2;
    if (mon_en) begin
      if (cmd_valid) begin
        mon_cnt++;
        chk(slot_rdy == 1'b1, "R7", "command after a non-ready slot", slot_rdy, 1);
        if (sb_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected command op", cmd_op, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(cmd_op == e.op, e.tag, "cmd_op", cmd_op, e.op);
          chk(cmd_bank == e.bank && cmd_row == e.row && cmd_col == e.col, "R11",
              "bank/row/col", {cmd_bank, cmd_row, cmd_col}, {e.bank, e.row, e.col});
        end
        chk(req_ack == cmd_op[1], "R8", "ack vs column command", req_ack, cmd_op[1]);
        chk(cmd_count == CNT_W'(mon_cnt), "R9", "cmd_count", cmd_count, mon_cnt);
      end else begin
        if (req_ack) chk(1'b0, "R8", "ack without command", req_ack, 0);
        if (slot_rdy && sb_q.size() != 0)
          chk(1'b0, "R7", "idle on a ready slot with work", cmd_valid, 1);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0; close_pol = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_bank = '0; req_row = '0; req_col = '0; slot_rdy = 1'b0;
    m_close = 0;
    for (int i = 0; i < NB; i++) begin m_open[i] = 0; m_row[i] = '0; end
    slot_mode = 2;
    repeat (4) @(negedge clk);
    chk(cmd_valid == 0 && req_ack == 0, "R1", "outputs in reset", {cmd_valid, req_ack}, 0);
    chk(cmd_count == 0, "R1", "count in reset", cmd_count, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cmd_valid == 0 && cmd_count == 0, "R1", "outputs after reset", {cmd_valid, cmd_count}, 0);
    mon_en = 1;
    slot_mode = 0;
    @(negedge clk);

    // Open policy: empty, conflict, back to first row (R2, R4)
    base = int'(cmd_count);
    send(2, 12'h010, 8'h00, 0, "R3");
    send(2, 12'h020, 8'h00, 0, "R3");
    send(2, 12'h010, 8'h01, 1, "R3");
    drain();
    chk(int'(cmd_count) - base == 8, "R9", "open-policy total, conflicting rows", int'(cmd_count) - base, 8);
    // Open policy keeps row: hits only (R3, R5)
    base = int'(cmd_count);
    send(2, 12'h010, 8'h02, 0, "R5");
    send(2, 12'h010, 8'h03, 1, "R3");
    send(2, 12'h010, 8'h04, 0, "R5");
    drain();
    chk(int'(cmd_count) - base == 3, "R5", "open-policy total, same row", int'(cmd_count) - base, 3);

    // Bank independence (R12)
    send(0, 12'h003, 8'h11, 0, "R3");
    send(1, 12'h007, 8'h22, 1, "R3");
    send(0, 12'h003, 8'h33, 0, "R12");
    send(1, 12'h007, 8'h44, 0, "R12");
    send(2, 12'h010, 8'h55, 1, "R12");
    drain();

    // Slot withheld, then alternating slots (R7)
    slot_mode = 2;
    @(negedge clk);
    base = int'(cmd_count);
    fork
      send(0, 12'h0AA, 8'h05, 0, "R3");
      begin
        repeat (6) @(negedge clk);
        chk(int'(cmd_count) == base, "R7", "commands with slot withheld", cmd_count, base);
        slot_mode = 1;
      end
    join
    send(1, 12'h007, 8'h06, 1, "R3");
    drain();
    slot_mode = 0;
    @(negedge clk);

    // Close policy on bank 3 (R6, R10): back-to-back requests
    close_pol = 1'b1;
    m_close   = 1;
    @(negedge clk);
    base = int'(cmd_count);
    send(3, 12'h010, 8'h00, 0, "R3");
    send(3, 12'h020, 8'h00, 0, "R3");
    send(3, 12'h010, 8'h01, 1, "R3");
    drain();
    chk(int'(cmd_count) - base == 9, "R6", "close-policy total, conflicting rows", int'(cmd_count) - base, 9);
    base = int'(cmd_count);
    send(3, 12'h010, 8'h02, 0, "R3");
    send(3, 12'h010, 8'h03, 1, "R3");
    send(3, 12'h010, 8'h04, 0, "R3");
    drain();
    chk(int'(cmd_count) - base == 9, "R6", "close-policy total, same row", int'(cmd_count) - base, 9);

    // Close policy with alternating slots across two banks
    slot_mode = 1;
    send(0, 12'h0AA, 8'h07, 1, "R3");
    send(1, 12'h0BB, 8'h08, 0, "R3");
    drain();
    slot_mode = 0;

    chk(int'(cmd_count) == mon_cnt, "R9", "final count", cmd_count, mon_cnt);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule